// File: doc/BRIEF.md
# Timer Input Edge Qualifier

This block turns an asynchronous timer input pin into one-clock edge pulses that a 16-bit timer/counter consumes, either as its count clock or as a capture trigger. The pin first crosses into the system clock domain through a short synchronizer. It is then sampled on one of two sampling enables: the main peripheral enable in count-clock use, or the prescaler-derived enable in capture use. In capture use a new level is accepted only once two consecutive samples agree, so that narrow noise pulses are dropped.

The block remembers the last accepted level. A system reset clears this memory to low. Stopping the timer only freezes it. As a result, enabling the timer can report an edge at once when the pin moved while the timer was stopped, or when the pin is already high after reset. The edge selection (falling, rising, both or none) is held in a register that accepts new values only while the timer is stopped.

Top module: `tmr_edge_qual`

## Requirements
- R1: The pin reaches the sampler through a two-flop synchronizer. In count-clock use with the sampling enable held high, a pin change applied just after a clock edge shows as a pulse during the cycle after the third following rising clock edge.
- R2: Edge-select codes: 2'b00 falling only, 2'b01 rising only, 2'b11 both, 2'b10 no edges at all.
- R3: In count-clock use (use_capture=0), sampling happens only on cycles with samp_en_main high. A single sample is accepted as the new level.
- R4: In capture use (use_capture=1), sampling happens only on cycles with samp_en_presc high. A level differing from the stored one is accepted only when two consecutive samples are equal, so a pulse seen by at most one sample is rejected.
- R5: Reset clears the stored level to low, the edge select to 2'b00 and edge_pulse to 0.
- R6: edge_pulse lasts one clock per accepted edge and is 0 whenever run is 0.
- R7: The stored level is frozen while run is 0. Enabling with the pin at the other level gives an immediate rising or falling edge, if that edge is selected.
- R8: A write of the edge select while run is 1 is ignored. A write while run is 0 takes effect.
- R9: On every clock, edge_pulse equals the value predicted by a behavioural model of R1 to R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| pin_async | input | 1 | Raw timer input pin |
| run | input | 1 | Timer enable |
| use_capture | input | 1 | 0: count-clock use, 1: capture use |
| samp_en_main | input | 1 | Sampling enable for count-clock use |
| samp_en_presc | input | 1 | Sampling enable for capture use, from the prescaler |
| sel_wr | input | 1 | Edge-select write strobe |
| sel_din | input | 2 | Edge-select value to write |
| edge_pulse | output | 1 | One-clock valid-edge pulse |

## Verification
The assertions assume that all inputs except pin_async are synchronous to clk. They also assume that run and use_capture change only between clock edges, and that the sampling enables are plain single-cycle strobes with no relation to the pin. The bench drives every input shortly after the falling clock edge. It generates the prescaler strobe from a free-running cycle counter every fourth cycle. It changes use_capture only while run is low, so the capture-filter check never sees a mode switch in the middle of a comparison.

// File: rtl/tmr_edge_pkg.sv
package tmr_edge_pkg;

  typedef enum logic [1:0] {
    SEL_FALL = 2'b00,
    SEL_RISE = 2'b01,
    SEL_NONE = 2'b10,
    SEL_BOTH = 2'b11
  } edge_sel_t;

  // Decide whether a transition old_lvl -> new_lvl is a valid edge under sel.
  function automatic logic edge_hit(input edge_sel_t sel, input logic old_lvl,
                                    input logic new_lvl);
    logic rise, fall;
    rise = !old_lvl && new_lvl;
    fall = old_lvl && !new_lvl;
    case (sel)
      SEL_FALL: edge_hit = fall;
      SEL_RISE: edge_hit = rise;
      SEL_BOTH: edge_hit = rise || fall;
      default:  edge_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/teq_sync.sv
module teq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d_async;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/teq_filter.sv
module teq_filter #(
  parameter int MATCH_SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic capture,
  input  logic smp_in,
  output logic acc_lvl,
  output logic acc_nxt,
  output logic smp_prev
);
  localparam int HW = MATCH_SAMPLES - 1;

  logic [HW-1:0] hist;
  logic          agree;

  always_comb begin
    agree = 1'b1;
    for (int i = 0; i < HW; i++) begin
      if (hist[i] != smp_in) agree = 1'b0;
    end
  end

  assign acc_nxt  = capture ? (agree ? smp_in : acc_lvl) : smp_in;
  assign smp_prev = hist[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist    <= '0;
      acc_lvl <= 1'b0;
    end else if (tick) begin
      hist[0] <= smp_in;
      for (int i = 1; i < HW; i++) hist[i] <= hist[i-1];
      acc_lvl <= acc_nxt;
    end
  end
endmodule

// File: rtl/teq_edge.sv
module teq_edge
  import tmr_edge_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  edge_sel_t sel,
  input  logic      acc_lvl,
  input  logic      acc_nxt,
  output logic      edge_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_q <= 1'b0;
    else        edge_q <= tick && edge_hit(sel, acc_lvl, acc_nxt);
  end
endmodule

// File: rtl/tmr_edge_qual.sv
module tmr_edge_qual
  import tmr_edge_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int MATCH_SAMPLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_async,
  input  logic       run,
  input  logic       use_capture,
  input  logic       samp_en_main,
  input  logic       samp_en_presc,
  input  logic       sel_wr,
  input  logic [1:0] sel_din,
  output logic       edge_pulse
);
  // Named internal events, brought out for the checker.
  logic      smp_s;
  logic      tick;
  logic      acc_lvl;
  logic      acc_nxt;
  logic      smp_prev;
  logic      edge_q;
  edge_sel_t sel_q;

  assign tick = run && (use_capture ? samp_en_presc : samp_en_main);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sel_q <= SEL_FALL;
    else if (sel_wr && !run) sel_q <= edge_sel_t'(sel_din);
  end

  teq_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_async(pin_async), .q_sync(smp_s)
  );

  teq_filter #(.MATCH_SAMPLES(MATCH_SAMPLES)) filt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .capture(use_capture),
    .smp_in(smp_s), .acc_lvl(acc_lvl), .acc_nxt(acc_nxt), .smp_prev(smp_prev)
  );

  teq_edge edge_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sel(sel_q),
    .acc_lvl(acc_lvl), .acc_nxt(acc_nxt), .edge_q(edge_q)
  );

  assign edge_pulse = edge_q && run;
endmodule

// File: rtl/tmr_edge_qual_chk.sv
module tmr_edge_qual_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       use_capture,
  input logic       tick,
  input logic       smp_in,
  input logic       smp_prev,
  input logic       acc_lvl,
  input logic [1:0] sel,
  input logic       edge_pulse
);
  // R6: no pulse while the timer is stopped
  a_r6_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !edge_pulse);

  // R7: stored level is frozen while stopped
  a_r7_level_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(acc_lvl));

  // R8: edge select cannot change while running
  a_r8_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(sel));

  // R2: code 2'b10 produces no edges
  a_r2_none_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b10) |-> !edge_pulse);

  // R4: in capture use a disagreeing sample pair leaves the level unchanged
  a_r4_filter_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && use_capture && (smp_in != smp_prev)) |=> $stable(acc_lvl));

  // R3/R4: without a sampling tick the stored level does not move
  a_r3_no_tick_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(acc_lvl));
endmodule

bind tmr_edge_qual tmr_edge_qual_chk chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .use_capture(use_capture),
  .tick(tick), .smp_in(smp_s), .smp_prev(smp_prev), .acc_lvl(acc_lvl),
  .sel(sel_q), .edge_pulse(edge_pulse)
);

// File: tb/tmr_edge_qual_tb_top.sv
`timescale 1ns/1ps
module tmr_edge_qual_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_async = 1'b0;
  logic       run = 1'b0;
  logic       use_capture = 1'b0;
  logic       samp_en_main = 1'b1;
  logic       samp_en_presc = 1'b0;
  logic       sel_wr = 1'b0;
  logic [1:0] sel_din = 2'b00;
  logic       edge_pulse;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  tmr_edge_qual dut_i (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .run(run),
    .use_capture(use_capture), .samp_en_main(samp_en_main),
    .samp_en_presc(samp_en_presc), .sel_wr(sel_wr), .sel_din(sel_din),
    .edge_pulse(edge_pulse)
  );

  // Prescaler strobe: one cycle in four.
  always @(negedge clk) begin
    cyc = cyc + 1;
    samp_en_presc = (cyc % 4 == 0);
  end

  // Behavioural reference model.
  bit pipe[$] = '{1'b0, 1'b0};
  int m_prev = 0, m_lvl = 0, m_sel = 0, m_exp = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe = '{1'b0, 1'b0};
      m_prev = 0; m_lvl = 0; m_sel = 0; m_exp = 0;
    end else begin
      int s, nl;
      bit smp_now;
      s = pipe[0];
      smp_now = run && (use_capture ? samp_en_presc : samp_en_main);
      m_exp = 0;
      if (smp_now) begin
        if (use_capture) nl = (s == m_prev) ? s : m_lvl;
        else             nl = s;
        if (nl > m_lvl && (m_sel == 1 || m_sel == 3)) m_exp = 1;
        if (nl < m_lvl && (m_sel == 0 || m_sel == 3)) m_exp = 1;
        m_prev = s;
        m_lvl = nl;
      end
      if (sel_wr && !run) m_sel = sel_din;
      void'(pipe.pop_front());
      pipe.push_back(pin_async);
    end
  end

  // R9: per-cycle comparison; also counts pulses.
  always @(negedge clk) begin
    if (rst_n) begin
      int want;
      want = (m_exp != 0 && run) ? 1 : 0;
      checks = checks + 1;
      if (int'(edge_pulse) != want) begin
        errors = errors + 1;
        $display("FAIL R9 model mismatch at cycle %0d: got %0d expected %0d",
                 cyc, edge_pulse, want);
      end
      if (edge_pulse) pulses = pulses + 1;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(input string req, input int got, input int exp);
    checks = checks + 1;
    if (got != exp) begin
      errors = errors + 1;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic write_sel(input logic [1:0] v);
    sel_din = v;
    sel_wr = 1'b1;
    step(1);
    sel_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL R9 watchdog expired: got timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    check("R5 output low in reset", int'(edge_pulse), 0);
    rst_n = 1'b1;
    step(2);

    // R5/R7: stored level low after reset, pin high on first enable
    pin_async = 1'b1;
    step(4);
    check("R6 no pulse while stopped", pulses, 0);
    write_sel(2'b01);
    pulses = 0;
    run = 1'b1;
    step(1);
    check("R7 immediate rising after reset", int'(edge_pulse), 1);
    step(5);
    check("R6 single pulse per edge", pulses, 1);

    // R1: synchronizer latency
    pin_async = 1'b0;
    step(6);
    pin_async = 1'b1;
    step(2);
    check("R1 no pulse before sync delay", int'(edge_pulse), 0);
    step(1);
    check("R1 pulse after three edges", int'(edge_pulse), 1);
    step(1);
    check("R6 pulse lasts one cycle", int'(edge_pulse), 0);

    // R7: stop high, restart low -> falling
    run = 1'b0;
    pin_async = 1'b0;
    step(6);
    write_sel(2'b00);
    pulses = 0;
    run = 1'b1;
    step(6);
    check("R7 immediate falling on restart", pulses, 1);

    // R8: write while running ignored (falling stays selected)
    write_sel(2'b10);
    pulses = 0;
    pin_async = 1'b1;
    step(8);
    pin_async = 1'b0;
    step(8);
    check("R8 running write ignored", pulses, 1);

    // R7: stop low, restart high -> rising
    run = 1'b0;
    pin_async = 1'b1;
    step(6);
    write_sel(2'b01);
    pulses = 0;
    run = 1'b1;
    step(6);
    check("R7 immediate rising on restart", pulses, 1);

    // R2: code 10 gives nothing
    run = 1'b0;
    write_sel(2'b10);
    run = 1'b1;
    pulses = 0;
    for (int i = 0; i < 4; i++) begin
      pin_async = ~pin_async;
      step(6);
    end
    check("R2 code 10 silent", pulses, 0);

    // R2: both edges
    run = 1'b0;
    write_sel(2'b11);
    run = 1'b1;
    step(6);
    pulses = 0;
    for (int i = 0; i < 2; i++) begin
      pin_async = ~pin_async;
      step(6);
    end
    check("R2 both edges counted", pulses, 2);

    // R3: count use samples only on main enable
    samp_en_main = 1'b0;
    pulses = 0;
    pin_async = ~pin_async;
    step(10);
    check("R3 no sampling without main enable", pulses, 0);
    samp_en_main = 1'b1;
    step(6);
    check("R3 sampling resumes with main enable", pulses, 1);

    // R4: capture use rejects a short pulse, accepts a stable level
    run = 1'b0;
    use_capture = 1'b1;
    pin_async = 1'b0;
    step(4);
    run = 1'b1;
    step(12);
    pulses = 0;
    pin_async = 1'b1;
    step(2);
    pin_async = 1'b0;
    step(16);
    check("R4 short pulse rejected", pulses, 0);
    pin_async = 1'b1;
    step(20);
    check("R4 stable level accepted", pulses, 1);

    run = 1'b0;
    step(2);
    check("R6 output low after stop", int'(edge_pulse), 0);
    finish_run();
  end
endmodule